// File: doc/BRIEF.md
# Basic-Block Code Integrity Checker

This block runs next to an in-order instruction pipeline and checks that the instruction words it executes are the ones that were expected. Each fetched word and its PC arrive on a fetch strobe. The block folds the words into an XOR checksum, one basic block at a time, and it records the PC of the first word of each block as that block's key. When decode reports a control-flow transfer, the block is complete. The checker then searches a small, fully associative table of (start address, expected checksum) pairs and reports one of three outcomes: hit, mismatch or miss.

Software fills the table through a dedicated write port. The port names the target entry, the start address and the expected checksum, so the entries for a cluster of blocks can be written back to back before the cluster runs. A flush input drops a partly accumulated block, for example when the pipeline is redirected.

The fetch strobe and the table write port are plain one-cycle qualifiers with no back-pressure. The checker accepts a word in every cycle where the fetch strobe is high, and it never stalls the pipeline. Results come out as one-cycle pulses and are not held.

Top module: `bb_integrity_checker`

## Requirements
- R1: After reset all outputs are low and every table entry is invalid, so the first lookup after reset reports a miss.
- R2: The dynamic checksum of a block is the XOR of all words accepted from the block's first word through the word accepted in the cycle just before `dec_xfer`. The lookup key is the PC of that first word.
- R3: A lookup is made only in a cycle where `dec_xfer` is high. In the following cycle `chk_done` pulses together with exactly one of `chk_hit`, `exc_mismatch` or `exc_miss`. In every other cycle all four outputs are low.
- R4: If a valid entry's address equals the key and its stored checksum equals the dynamic checksum, the result is a hit (`chk_hit`), and neither exception is raised.
- R5: If a valid entry's address equals the key but its checksum differs from the dynamic checksum, `exc_mismatch` is raised.
- R6: If no valid entry's address equals the key, `exc_miss` is raised.
- R7: A word accepted in the same cycle as `dec_xfer` is the first word of the next block. It starts a fresh checksum, and its PC becomes the next key.
- R8: When `flush` is high, the partial checksum is discarded and a `dec_xfer` in that cycle produces no result. A word offered in that cycle is ignored, and the next accepted word starts a new block.
- R9: A table write with `wr_en` high fills entry `wr_idx` with `wr_addr` and `wr_hash` and marks the entry valid. A lookup in the same cycle still sees the old contents, and the new contents are used from the next cycle on.
- R10: If several valid entries hold the key address, the entry with the lowest index decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | A fetched word is presented this cycle |
| fetch_pc | input | ADDR_W | PC of the fetched word |
| fetch_word | input | WORD_W | Fetched instruction word |
| dec_xfer | input | 1 | Decode saw a control transfer; the current block ends |
| flush | input | 1 | Drop the partial block |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_addr | input | ADDR_W | Block start address to store |
| wr_hash | input | WORD_W | Expected checksum to store |
| chk_done | output | 1 | A lookup result is valid this cycle |
| chk_hit | output | 1 | Block found with a matching checksum |
| exc_mismatch | output | 1 | Block found with a different checksum |
| exc_miss | output | 1 | Block start address not in the table |

## Verification
The properties assume that `dec_xfer` comes only in the cycle right after an accepted, non-flushed word. That is the point where decode sees the transfer word. The stimulus keeps to this rule: it raises `dec_xfer` only one cycle after a block's last word. If idle or flush cycles come in between, they carry that pending transfer instead. The stimulus also only writes entries whose index lies below the table depth. Random blocks drawn from a small pool of start addresses cause frequent key collisions and rewrites. Directed cases cover a write in the same cycle as the lookup, duplicate keys, and a flush that lands on a transfer.

// File: rtl/bbic_pkg.sv
package bbic_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE     = 2'd0,
    VERDICT_HIT      = 2'd1,
    VERDICT_MISMATCH = 2'd2,
    VERDICT_MISS     = 2'd3
  } verdict_e;

  // index width that stays at least one bit for a single-entry table
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bbic_fold.sv
// Running XOR checksum and start-address capture for the current basic block.
module bbic_fold #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              blk_end,
  input  logic              flush,
  output logic [ADDR_W-1:0] blk_key,
  output logic [WORD_W-1:0] blk_sum
);

  logic              start_pend;
  logic              restart;
  logic [WORD_W-1:0] sum_q;
  logic [ADDR_W-1:0] key_q;

  // a word arriving alongside the block end belongs to the next block
  assign restart = start_pend | blk_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q      <= '0;
      key_q      <= '0;
      start_pend <= 1'b1;
    end else if (flush) begin
      sum_q      <= '0;
      start_pend <= 1'b1;
    end else if (fetch_valid) begin
      sum_q      <= (restart ? '0 : sum_q) ^ fetch_word;
      if (restart) key_q <= fetch_pc;
      start_pend <= 1'b0;
    end else if (blk_end) begin
      start_pend <= 1'b1;
    end
  end

  assign blk_key = key_q;
  assign blk_sum = sum_q;

endmodule

// File: rtl/bbic_table.sv
// Small fully associative table of (start address, expected checksum) pairs.
module bbic_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_hash,
  input  logic [ADDR_W-1:0] look_key,
  output logic              look_found,
  output logic [WORD_W-1:0] look_hash
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [WORD_W-1:0]  hash_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (32'(wr_idx) == e);

    always_ff @(posedge clk) begin
      if (rst) valid_q[e] <= 1'b0;
      else if (sel) valid_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        addr_q[e] <= wr_addr;
        hash_q[e] <= wr_hash;
      end
    end

    assign match[e] = valid_q[e] && (addr_q[e] == look_key);
  end

  // lowest matching index wins: scan downward so it is assigned last
  always_comb begin
    look_found = 1'b0;
    look_hash  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        look_found = 1'b1;
        look_hash  = hash_q[i];
      end
    end
  end

endmodule

// File: rtl/bbic_verdict.sv
// Compares the dynamic and stored checksums and registers the outcome.
module bbic_verdict
  import bbic_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evaluate,
  input  logic              found,
  input  logic [WORD_W-1:0] stored_sum,
  input  logic [WORD_W-1:0] dyn_sum,
  output verdict_e          verdict
);

  verdict_e verdict_q;

  always_ff @(posedge clk) begin
    if (rst) verdict_q <= VERDICT_NONE;
    else if (!evaluate) verdict_q <= VERDICT_NONE;
    else if (!found) verdict_q <= VERDICT_MISS;
    else if (stored_sum == dyn_sum) verdict_q <= VERDICT_HIT;
    else verdict_q <= VERDICT_MISMATCH;
  end

  assign verdict = verdict_q;

endmodule

// File: rtl/bb_integrity_checker.sv
module bb_integrity_checker
  import bbic_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              dec_xfer,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_hash,
  output logic              chk_done,
  output logic              chk_hit,
  output logic              exc_mismatch,
  output logic              exc_miss
);

  logic [ADDR_W-1:0] blk_key;
  logic [WORD_W-1:0] blk_sum;
  logic              found;
  logic [WORD_W-1:0] stored_sum;
  verdict_e          verdict;

  bbic_fold #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fold (
    .clk        (clk),
    .rst        (rst),
    .fetch_valid(fetch_valid),
    .fetch_pc   (fetch_pc),
    .fetch_word (fetch_word),
    .blk_end    (dec_xfer),
    .flush      (flush),
    .blk_key    (blk_key),
    .blk_sum    (blk_sum)
  );

  bbic_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_addr   (wr_addr),
    .wr_hash   (wr_hash),
    .look_key  (blk_key),
    .look_found(found),
    .look_hash (stored_sum)
  );

  bbic_verdict #(.WORD_W(WORD_W)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .evaluate  (dec_xfer & ~flush),
    .found     (found),
    .stored_sum(stored_sum),
    .dyn_sum   (blk_sum),
    .verdict   (verdict)
  );

  assign chk_done     = (verdict != VERDICT_NONE);
  assign chk_hit      = (verdict == VERDICT_HIT);
  assign exc_mismatch = (verdict == VERDICT_MISMATCH);
  assign exc_miss     = (verdict == VERDICT_MISS);

endmodule

// File: rtl/bbic_checker.sv
module bbic_checker (
  input logic clk,
  input logic rst,
  input logic dec_xfer,
  input logic flush,
  input logic wr_en,
  input logic chk_done,
  input logic chk_hit,
  input logic exc_mismatch,
  input logic exc_miss
);

  logic ever_written;

  always_ff @(posedge clk) begin
    if (rst) ever_written <= 1'b0;
    else if (wr_en) ever_written <= 1'b1;
  end

  // R3: at most one outcome at a time
  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chk_hit, exc_mismatch, exc_miss}));

  // R3: a done pulse always carries exactly one outcome
  assert_done_has_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> ($countones({chk_hit, exc_mismatch, exc_miss}) == 1));

  // R3: a transfer without flush yields a result one cycle later
  assert_result_follows_xfer_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_xfer && !flush) |=> chk_done);

  // R3: no result without a preceding transfer
  assert_no_spurious_result_R3: assert property (@(posedge clk) disable iff (rst)
    !(dec_xfer && !flush) |=> !chk_done);

  // R8: a flush suppresses the lookup of that cycle
  assert_flush_suppresses_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !chk_done);

  // R1, R6: an empty table can only miss
  assert_empty_table_misses_R6: assert property (@(posedge clk) disable iff (rst)
    (!ever_written && !wr_en && dec_xfer && !flush) |=> exc_miss);

endmodule

bind bb_integrity_checker bbic_checker u_bbic_checker (
  .clk         (clk),
  .rst         (rst),
  .dec_xfer    (dec_xfer),
  .flush       (flush),
  .wr_en       (wr_en),
  .chk_done    (chk_done),
  .chk_hit     (chk_hit),
  .exc_mismatch(exc_mismatch),
  .exc_miss    (exc_miss)
);

// File: tb/bb_integrity_checker_bench.sv
`timescale 1ns/1ps
module bb_integrity_checker_bench;
  localparam int ENT = 8;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid, dec_xfer, flush, wr_en;
  logic [31:0]   fetch_pc, fetch_word, wr_addr, wr_hash;
  logic [IW-1:0] wr_idx;
  logic          chk_done, chk_hit, exc_mismatch, exc_miss;

  always #4 clk = ~clk;

  bb_integrity_checker #(.ENTRIES(ENT), .ADDR_W(32), .WORD_W(32)) u_bb_integrity_checker (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_word(fetch_word), .dec_xfer(dec_xfer), .flush(flush), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_hash(wr_hash), .chk_done(chk_done),
    .chk_hit(chk_hit), .exc_mismatch(exc_mismatch), .exc_miss(exc_miss)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_tag = "";

  // reference state
  logic        m_v [ENT];
  logic [31:0] m_a [ENT];
  logic [31:0] m_h [ENT];
  logic [31:0] m_sum, m_key;
  logic        m_start;
  logic        xfer_due;
  logic [31:0] wbuf [8];

  // expected {done,hit,mismatch,miss}
  function automatic logic [3:0] predict();
    for (int i = 0; i < ENT; i++)
      if (m_v[i] && m_a[i] == m_key) return (m_h[i] == m_sum) ? 4'b1100 : 4'b1010;
    return 4'b1001;
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: outputs done/hit/mism/miss got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic fv, input logic [31:0] pc, input logic [31:0] w,
                     input logic last, input logic fl, input logic we,
                     input logic [IW-1:0] wi, input logic [31:0] wa, input logic [31:0] wh);
    logic [3:0] exp;
    logic st;
    string tag;
    fetch_valid = fv; fetch_pc = pc; fetch_word = w; dec_xfer = xfer_due;
    flush = fl; wr_en = we; wr_idx = wi; wr_addr = wa; wr_hash = wh;
    exp = (xfer_due && !fl) ? predict() : 4'b0000;
    @(posedge clk);
    if (fl) begin
      m_sum = '0; m_start = 1'b1;
    end else begin
      st = m_start | xfer_due;
      if (fv) begin
        m_sum = (st ? 32'd0 : m_sum) ^ w;
        if (st) m_key = pc;
        m_start = 1'b0;
      end else if (xfer_due) m_start = 1'b1;
    end
    if (we) begin m_v[wi] = 1'b1; m_a[wi] = wa; m_h[wi] = wh; end
    xfer_due = fv && !fl && last;
    @(negedge clk);
    if (cur_tag != "") tag = cur_tag;
    else case (exp)
      4'b1100: tag = "R4";
      4'b1010: tag = "R5";
      4'b1001: tag = "R6";
      default: tag = "R3";
    endcase
    check(tag, {chk_done, chk_hit, exc_mismatch, exc_miss}, exp);
  endtask

  task automatic idle();
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  function automatic logic [31:0] bufsum(input int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s ^= wbuf[i];
    return s;
  endfunction

  // one block from wbuf; optional write during its first word
  task automatic blk(input logic [31:0] pc0, input int n, input logic we,
                     input logic [IW-1:0] wi, input logic [31:0] wa, input logic [31:0] wh,
                     input bit bubbles);
    for (int i = 0; i < n; i++) begin
      if (bubbles && ($urandom % 4 == 0)) idle();
      cyc(1'b1, pc0 + 32'(4 * i), wbuf[i], i == n - 1, 1'b0,
          we && (i == 0), wi, wa, wh);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] h;
    int unsigned seed;
    seed = $urandom(32'd1357);
    for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_a[i] = 0; m_h[i] = 0; end
    m_sum = 0; m_key = 0; m_start = 1; xfer_due = 0;
    fetch_valid = 0; fetch_pc = 0; fetch_word = 0; dec_xfer = 0; flush = 0;
    wr_en = 0; wr_idx = 0; wr_addr = 0; wr_hash = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {chk_done, chk_hit, exc_mismatch, exc_miss}, 4'b0000);
    rst = 0;

    // R1 R2: empty table misses
    cur_tag = "R1";
    wbuf[0] = 32'hA5A5_0001; wbuf[1] = 32'h0F0F_1234;
    blk(32'h40, 2, 0, 0, 0, 0, 0); idle();

    // R2 R4: correct checksum stored at entry 2
    cur_tag = "R2";
    blk(32'h40, 2, 1, 3'd2, 32'h40, bufsum(2), 0); idle();

    // R5: wrong checksum for 0x80
    cur_tag = "R5";
    wbuf[0] = 32'h1111_2222; wbuf[1] = 32'h3333_0000; wbuf[2] = 32'h0000_0007;
    blk(32'h80, 3, 1, 3'd5, 32'h80, 32'hDEAD_BEEF, 0); idle();

    // R10: entry 1 wrong, entry 6 right -> lowest index decides
    cur_tag = "R10";
    cyc(0, 0, 0, 0, 0, 1, 3'd6, 32'h80, bufsum(3));
    blk(32'h80, 3, 1, 3'd1, 32'h80, 32'h0BAD_0BAD, 0); idle();
    blk(32'h80, 3, 1, 3'd1, 32'h80, bufsum(3), 0); idle();

    // R9: write in the lookup cycle is not seen, then is seen
    cur_tag = "R9";
    wbuf[0] = 32'h7777_7777;
    h = wbuf[0];
    blk(32'h40, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 3'd2, 32'h40, h);
    blk(32'h40, 1, 0, 0, 0, 0, 0); idle();

    // R7: back-to-back blocks, next word fetched with the transfer
    cur_tag = "R7";
    wbuf[0] = 32'h1234_5678;
    blk(32'h40, 1, 0, 0, 0, 0, 0);
    wbuf[0] = 32'h1111_2222; wbuf[1] = 32'h3333_0000; wbuf[2] = 32'h0000_0007;
    blk(32'h80, 3, 0, 0, 0, 0, 0); idle();

    // R8: partial block discarded by flush
    cur_tag = "R8";
    cyc(1, 32'h40, 32'hFFFF_0000, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h44, 32'h0000_00FF, 0, 1, 0, 0, 0, 0);
    wbuf[0] = 32'h7777_7777;
    blk(32'h40, 1, 0, 0, 0, 0, 0); idle();
    // R8: flush on the transfer cycle gives no result
    blk(32'h40, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); idle();

    // random blocks over a small address pool
    cur_tag = "";
    for (int b = 0; b < 400; b++) begin
      logic [31:0] pc0;
      int n, mode;
      pc0 = 32'h1000 + 32'h100 * ($urandom % 6);
      n = 1 + ($urandom % 5);
      for (int i = 0; i < n; i++) wbuf[i] = $urandom;
      mode = $urandom % 4;
      if ($urandom % 25 == 0) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
      blk(pc0, n, mode < 2, IW'($urandom % ENT), pc0,
          (mode == 0) ? bufsum(n) : (bufsum(n) ^ (32'd1 << ($urandom % 32))), 1);
      if ($urandom % 3 == 0) idle();
    end
    idle(); idle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule